// File: doc/BRIEF.md
# Keyed Hash Sorter

This block groups incoming records by a small key so that all records sharing a key can later be read back together, however many there are. Each push carries a key and a data word; the block writes the record into the next free slot of a record memory, links it in front of the list already held for that key, and points the per-key head entry at it. A pop for a key then walks that list, presenting one record per cycle, newest first, until the chain ends.

Every head entry and every record is tagged with the event number that was current when it was written. A synchronous new-event pulse advances the event number and rewinds the free-slot counter. Everything stored under the previous event is then treated as absent, with no clearing pass over the head table. A re-pop replays the list captured at the most recent pop, and a wait input freezes the walk so that a slow consumer can hold the current record.

Top module: `hs_sorter`

## Requirements
- R1: After reset, `rdy_o` is 1 and `out_vld_o` is 0.
- R2: Accepted pushes are written at record identifiers 0, 1, 2, ... counted from reset or from the last new-event pulse, and that identifier is shown on `out_id_o` when the record is walked. Once 2^ID_W records are held, further pushes are dropped.
- R3: A pop accepted while `rdy_o` is 1 produces, from the next cycle on, one record per cycle in reverse push order with `out_vld_o` at 1 and `rdy_o` at 0. `out_last_o` is 1 only on the final record, and `rdy_o` returns to 1 in the cycle after that record.
- R4: A pop of a key with no record in the current event produces no output, and `rdy_o` stays at 1.
- R5: While `wait_i` is 1 during a walk, the presented record does not change and the walk does not advance.
- R6: A pop or re-pop issued during a walk is ignored, and the walk in progress continues unchanged.
- R7: A re-pop replays the list captured at the most recent pop from its first record. Records pushed to that key after that pop are not included.
- R8: A new-event pulse (`sr_i`) aborts any walk in the next cycle, rewinds the free counter to 0 and makes every list stored before it empty, including the list a re-pop would replay. A push in the same cycle is dropped.
- R9: A push and a pop for the same key in the same cycle: the pop excludes the record being pushed, and a later pop includes it.
- R10: Lists under different keys are independent: a walk returns only records pushed with its own key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_i | input | 1 | New-event pulse: advance event number, rewind free counter |
| push_i | input | 1 | Store a record |
| push_key_i | input | KEY_W | Key of the pushed record |
| push_data_i | input | DATA_W | Data word of the pushed record |
| pop_i | input | 1 | Start walking the list of `pop_key_i` |
| pop_key_i | input | KEY_W | Key to walk |
| repop_i | input | 1 | Replay the list captured at the last pop |
| wait_i | input | 1 | Hold the current record |
| rdy_o | output | 1 | No walk in progress; pop and re-pop are accepted |
| out_vld_o | output | 1 | A record is presented |
| out_last_o | output | 1 | Presented record is the final one of the list |
| out_id_o | output | ID_W | Identifier of the presented record |
| out_data_o | output | DATA_W | Data word of the presented record |

## Verification
The bench builds the block with 3-bit keys, a 3-bit event number, 4-bit record identifiers and 8-bit data. With only 16 record slots and 8 keys, it can fill the store to capacity and push past it. It can walk every key, including the empty ones, and compare each list against an arithmetic model of reverse push order. The short lists also let it place a stall, an intruding pop and a new-event pulse at chosen positions within a walk.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic {
        W_IDLE = 1'b0,
        W_RUN  = 1'b1
    } walk_e;

    // A link may be followed only when it exists and its target belongs to
    // the event that is current now.
    function automatic logic link_live(input logic has_link, input logic ev_match);
        return has_link & ev_match;
    endfunction

endpackage

// File: rtl/hs_head_table.sv
module hs_head_table #(
    parameter int KEY_W = 9,
    parameter int EV_W  = 10,
    parameter int ID_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EV_W-1:0]  cur_ev_i,
    input  logic [KEY_W-1:0] a_key_i,
    output logic             a_hit_o,
    output logic [ID_W-1:0]  a_id_o,
    input  logic [KEY_W-1:0] b_key_i,
    output logic             b_hit_o,
    output logic [ID_W-1:0]  b_id_o,
    input  logic             wr_en_i,
    input  logic [KEY_W-1:0] wr_key_i,
    input  logic [ID_W-1:0]  wr_id_i
);
    localparam int NKEY = 1 << KEY_W;

    logic [EV_W-1:0] ev_mem [NKEY];
    logic [ID_W-1:0] id_mem [NKEY];
    logic [NKEY-1:0] seen_d, seen_q;

    always_comb begin
        seen_d = seen_q;
        if (wr_en_i) seen_d[wr_key_i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= '0;
        else        seen_q <= seen_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            ev_mem[wr_key_i] <= cur_ev_i;
            id_mem[wr_key_i] <= wr_id_i;
        end
    end

    // A head from another event counts as an empty list.
    assign a_hit_o = seen_q[a_key_i] && (ev_mem[a_key_i] == cur_ev_i);
    assign a_id_o  = id_mem[a_key_i];
    assign b_hit_o = seen_q[b_key_i] && (ev_mem[b_key_i] == cur_ev_i);
    assign b_id_o  = id_mem[b_key_i];

    // R2: a written head is marked present in the following cycle
    p_head_marked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> seen_q[$past(wr_key_i)]);

endmodule

// File: rtl/hs_rec_mem.sv
module hs_rec_mem #(
    parameter int ID_W   = 8,
    parameter int EV_W   = 10,
    parameter int DATA_W = 28
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [ID_W-1:0]   wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [EV_W-1:0]   wr_ev_i,
    input  logic              wr_link_i,
    input  logic [ID_W-1:0]   wr_next_i,
    input  logic [ID_W-1:0]   a_addr_i,
    output logic [DATA_W-1:0] a_data_o,
    output logic [EV_W-1:0]   a_ev_o,
    output logic              a_link_o,
    output logic [ID_W-1:0]   a_next_o,
    input  logic [ID_W-1:0]   b_addr_i,
    output logic [EV_W-1:0]   b_ev_o
);
    localparam int DEPTH = 1 << ID_W;

    logic [DATA_W-1:0] data_mem [DEPTH];
    logic [EV_W-1:0]   ev_mem   [DEPTH];
    logic [ID_W-1:0]   next_mem [DEPTH];
    logic [DEPTH-1:0]  link_mem;

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            data_mem[wr_addr_i] <= wr_data_i;
            ev_mem[wr_addr_i]   <= wr_ev_i;
            next_mem[wr_addr_i] <= wr_next_i;
            link_mem[wr_addr_i] <= wr_link_i;
        end
    end

    assign a_data_o = data_mem[a_addr_i];
    assign a_ev_o   = ev_mem[a_addr_i];
    assign a_link_o = link_mem[a_addr_i];
    assign a_next_o = next_mem[a_addr_i];
    assign b_ev_o   = ev_mem[b_addr_i];

endmodule

// File: rtl/hs_walker.sv
module hs_walker
    import hs_pkg::*;
#(
    parameter int ID_W = 8,
    parameter int EV_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            abort_i,
    input  logic            wait_i,
    input  logic [EV_W-1:0] cur_ev_i,
    input  logic            pop_i,
    input  logic            pop_hit_i,
    input  logic [ID_W-1:0] pop_id_i,
    input  logic            repop_i,
    input  logic            rec_link_i,
    input  logic [ID_W-1:0] rec_next_i,
    input  logic [EV_W-1:0] next_ev_i,
    output logic            act_o,
    output logic            last_o,
    output logic [ID_W-1:0] ptr_o
);
    typedef struct packed {
        walk_e           st;
        logic [ID_W-1:0] ptr;
        logic            sv_hit;
        logic [ID_W-1:0] sv_id;
    } wstate_t;

    wstate_t d, q;
    logic    more;

    assign more = link_live(rec_link_i, next_ev_i == cur_ev_i);

    always_comb begin
        d = q;
        if (abort_i) begin
            d.st     = W_IDLE;
            d.sv_hit = 1'b0;
        end else if (q.st == W_RUN) begin
            if (!wait_i) begin
                if (more) d.ptr = rec_next_i;
                else      d.st  = W_IDLE;
            end
        end else if (pop_i) begin
            d.sv_hit = pop_hit_i;
            d.sv_id  = pop_id_i;
            if (pop_hit_i) begin
                d.st  = W_RUN;
                d.ptr = pop_id_i;
            end
        end else if (repop_i && q.sv_hit) begin
            d.st  = W_RUN;
            d.ptr = q.sv_id;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: W_IDLE, ptr: '0, sv_hit: 1'b0, sv_id: '0};
        else        q <= d;
    end

    assign act_o  = (q.st == W_RUN);
    assign last_o = act_o && !more;
    assign ptr_o  = q.ptr;

    // R5: a held walk keeps its position
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == W_RUN && wait_i && !abort_i) |=> (q.st == W_RUN && $stable(q.ptr)));

    // R8: a new event ends any walk
    p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (q.st == W_IDLE));

    // R6: an idle-only request cannot move a running walk off its chain
    p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == W_RUN && !abort_i && wait_i && (pop_i || repop_i)) |=> $stable(q.sv_id));

endmodule

// File: rtl/hs_sorter.sv
module hs_sorter
    import hs_pkg::*;
#(
    parameter int KEY_W  = 9,
    parameter int EV_W   = 10,
    parameter int ID_W   = 8,
    parameter int DATA_W = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sr_i,
    input  logic              push_i,
    input  logic [KEY_W-1:0]  push_key_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              pop_i,
    input  logic [KEY_W-1:0]  pop_key_i,
    input  logic              repop_i,
    input  logic              wait_i,
    output logic              rdy_o,
    output logic              out_vld_o,
    output logic              out_last_o,
    output logic [ID_W-1:0]   out_id_o,
    output logic [DATA_W-1:0] out_data_o
);
    localparam int DEPTH = 1 << ID_W;
    localparam int CNT_W = ID_W + 1;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [EV_W-1:0]  ev;
        logic [CNT_W-1:0] cnt;
    } ctl_t;

    ctl_t d, q;

    logic            push_ok;
    logic            pop_hit, push_hit;
    logic [ID_W-1:0] pop_head, push_head;
    logic            rec_link;
    logic [ID_W-1:0] rec_next, ptr;
    logic [EV_W-1:0] rec_ev, next_ev;
    logic            act, last;

    assign push_ok = push_i && !sr_i && (q.cnt != FULL);

    always_comb begin
        d = q;
        if (sr_i) begin
            d.ev  = q.ev + 1'b1;
            d.cnt = '0;
        end else if (push_ok) begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    hs_head_table #(.KEY_W(KEY_W), .EV_W(EV_W), .ID_W(ID_W)) u_head (
        .clk      (clk),
        .rst_n    (rst_n),
        .cur_ev_i (q.ev),
        .a_key_i  (pop_key_i),
        .a_hit_o  (pop_hit),
        .a_id_o   (pop_head),
        .b_key_i  (push_key_i),
        .b_hit_o  (push_hit),
        .b_id_o   (push_head),
        .wr_en_i  (push_ok),
        .wr_key_i (push_key_i),
        .wr_id_i  (q.cnt[ID_W-1:0])
    );

    hs_rec_mem #(.ID_W(ID_W), .EV_W(EV_W), .DATA_W(DATA_W)) u_rec (
        .clk       (clk),
        .wr_en_i   (push_ok),
        .wr_addr_i (q.cnt[ID_W-1:0]),
        .wr_data_i (push_data_i),
        .wr_ev_i   (q.ev),
        .wr_link_i (push_hit),
        .wr_next_i (push_head),
        .a_addr_i  (ptr),
        .a_data_o  (out_data_o),
        .a_ev_o    (rec_ev),
        .a_link_o  (rec_link),
        .a_next_o  (rec_next),
        .b_addr_i  (rec_next),
        .b_ev_o    (next_ev)
    );

    hs_walker #(.ID_W(ID_W), .EV_W(EV_W)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .abort_i    (sr_i),
        .wait_i     (wait_i),
        .cur_ev_i   (q.ev),
        .pop_i      (pop_i),
        .pop_hit_i  (pop_hit),
        .pop_id_i   (pop_head),
        .repop_i    (repop_i),
        .rec_link_i (rec_link),
        .rec_next_i (rec_next),
        .next_ev_i  (next_ev),
        .act_o      (act),
        .last_o     (last),
        .ptr_o      (ptr)
    );

    assign rdy_o      = !act;
    assign out_vld_o  = act;
    assign out_last_o = last;
    assign out_id_o   = ptr;

    // R2: the free counter never passes the record capacity
    p_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= FULL);

    // R2: a full store stays full until a new event
    p_full_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt == FULL && !sr_i) |=> (q.cnt == FULL));

    // R8: a new event rewinds the counter and silences the output
    p_new_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sr_i |=> (q.cnt == '0 && !out_vld_o));

    // R3: every presented record belongs to the current event
    p_live_rec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld_o |-> (rec_ev == q.ev));

endmodule

// File: tb/sim_hs_sorter.sv
`timescale 1ns/1ps
module sim_hs_sorter;
    localparam int KW = 3, EW = 3, IW = 4, DW = 8;
    localparam int NREC = 1 << IW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sr_i = 0, push_i = 0, pop_i = 0, repop_i = 0, wait_i = 0;
    logic [KW-1:0] push_key_i = '0, pop_key_i = '0;
    logic [DW-1:0] push_data_i = '0;
    logic rdy_o, out_vld_o, out_last_o;
    logic [IW-1:0] out_id_o;
    logic [DW-1:0] out_data_o;

    int n_tests = 0, n_fail = 0, seq = 0;
    int mkey [NREC];
    int mdat [NREC];
    int nrec = 0;
    int sn_id [NREC];
    int sn_dat [NREC];
    int sn_n = 0;

    always #4 clk = ~clk;

    hs_sorter #(.KEY_W(KW), .EV_W(EW), .ID_W(IW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .sr_i(sr_i), .push_i(push_i),
        .push_key_i(push_key_i), .push_data_i(push_data_i),
        .pop_i(pop_i), .pop_key_i(pop_key_i), .repop_i(repop_i), .wait_i(wait_i),
        .rdy_o(rdy_o), .out_vld_o(out_vld_o), .out_last_o(out_last_o),
        .out_id_o(out_id_o), .out_data_o(out_data_o));

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int next_data();
        seq++;
        return (seq * 37 + 11) & 255;
    endfunction

    task automatic model_add(input int key, input int dat);
        if (nrec < NREC) begin
            mkey[nrec] = key;
            mdat[nrec] = dat;
            nrec++;
        end
    endtask

    task automatic push(input int key);
        int dat;
        dat = next_data();
        @(negedge clk);
        push_i = 1; push_key_i = KW'(key); push_data_i = DW'(dat);
        @(negedge clk);
        push_i = 0;
        model_add(key, dat);
    endtask

    task automatic take_snapshot(input int key);
        sn_n = 0;
        for (int i = nrec - 1; i >= 0; i--) begin
            if (mkey[i] == key) begin
                sn_id[sn_n] = i;
                sn_dat[sn_n] = mdat[i];
                sn_n++;
            end
        end
    endtask

    task automatic walk(input bit rep, input int key, input int stall_at,
                        input int intr_at, input bit also_push, input string req);
        int pdat;
        pdat = 0;
        if (!rep) take_snapshot(key);
        @(negedge clk);
        if (rep) repop_i = 1;
        else begin pop_i = 1; pop_key_i = KW'(key); end
        if (also_push) begin
            pdat = next_data();
            push_i = 1; push_key_i = KW'(key); push_data_i = DW'(pdat);
        end
        @(negedge clk);
        pop_i = 0; repop_i = 0; push_i = 0;
        if (also_push) model_add(key, pdat);
        for (int s = 0; s < sn_n; s++) begin
            chk(out_vld_o === 1'b1, req, "out_vld", int'(out_vld_o), 1);
            chk(rdy_o === 1'b0, req, "rdy while walking", int'(rdy_o), 0);
            chk(int'(out_id_o) == sn_id[s], req, "out_id", int'(out_id_o), sn_id[s]);
            chk(int'(out_data_o) == sn_dat[s], req, "out_data", int'(out_data_o), sn_dat[s]);
            chk(out_last_o === (s == sn_n - 1), req, "out_last", int'(out_last_o),
                int'(s == sn_n - 1));
            if (s == stall_at) begin
                wait_i = 1;
                @(negedge clk);
                wait_i = 0;
                // R5: held record unchanged
                chk(out_vld_o === 1'b1 && int'(out_id_o) == sn_id[s], "R5",
                    "held id", int'(out_id_o), sn_id[s]);
                chk(int'(out_data_o) == sn_dat[s], "R5", "held data",
                    int'(out_data_o), sn_dat[s]);
            end
            if (s == intr_at) begin
                // R6: intruding requests during a walk
                pop_i = 1; repop_i = 1; pop_key_i = KW'((key + 1) % 8);
            end
            @(negedge clk);
            pop_i = 0; repop_i = 0;
        end
        chk(out_vld_o === 1'b0, req, "out_vld after list", int'(out_vld_o), 0);
        chk(rdy_o === 1'b1, req, "rdy after list", int'(rdy_o), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got 0 expected 1 (run completion)");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(rdy_o === 1'b1, "R1", "rdy", int'(rdy_o), 1);
        chk(out_vld_o === 1'b0, "R1", "out_vld", int'(out_vld_o), 0);

        // R4: nothing stored yet
        walk(0, 2, -1, -1, 0, "R4");

        // R10: three interleaved keys
        for (int i = 0; i < 10; i++) push(i % 3);
        for (int k = 0; k < 8; k++) walk(0, k, -1, -1, 0, (k < 3) ? "R10" : "R4");
        walk(0, 0, -1, -1, 0, "R3");

        // R5 stall mid-list, R6 intruding pop
        walk(0, 0, 1, 0, 0, "R6");
        walk(0, 1, 0, 3, 0, "R5");

        // R7: replay, then add records and replay the old snapshot
        walk(0, 0, -1, -1, 0, "R3");
        walk(1, 0, -1, -1, 0, "R7");
        push(0); push(0);
        walk(1, 0, 2, -1, 0, "R7");
        walk(0, 0, -1, -1, 0, "R7");

        // R9: push and pop of one key together
        walk(0, 1, -1, -1, 1, "R9");
        walk(0, 1, -1, -1, 0, "R9");

        // R2: fill past capacity
        for (int i = 0; i < 6; i++) push(2);
        walk(0, 2, -1, -1, 0, "R2");
        walk(0, 0, -1, -1, 0, "R2");
        push(5);
        walk(0, 5, -1, -1, 0, "R2");

        // R8: new event with a simultaneous push
        @(negedge clk);
        sr_i = 1; push_i = 1; push_key_i = 3'd3; push_data_i = 8'd99;
        @(negedge clk);
        sr_i = 0; push_i = 0;
        nrec = 0; sn_n = 0;
        walk(0, 0, -1, -1, 0, "R8");
        walk(0, 3, -1, -1, 0, "R8");
        walk(0, 1, -1, -1, 0, "R8");
        walk(1, 1, -1, -1, 0, "R8");
        push(5);
        walk(0, 5, -1, -1, 0, "R8");
        chk(sn_n == 1 && sn_id[0] == 0, "R8", "first id after new event", sn_id[0], 0);

        // R8: new event aborts a running walk
        push(4); push(4); push(4);
        take_snapshot(4);
        @(negedge clk);
        pop_i = 1; pop_key_i = 3'd4;
        @(negedge clk);
        pop_i = 0;
        chk(out_vld_o === 1'b1 && int'(out_id_o) == sn_id[0], "R8", "walk started",
            int'(out_id_o), sn_id[0]);
        sr_i = 1;
        @(negedge clk);
        sr_i = 0;
        nrec = 0; sn_n = 0;
        chk(out_vld_o === 1'b0, "R8", "out_vld after abort", int'(out_vld_o), 0);
        chk(rdy_o === 1'b1, "R8", "rdy after abort", int'(rdy_o), 1);
        walk(1, 4, -1, -1, 0, "R8");
        walk(0, 4, -1, -1, 0, "R8");

        // R2: counter restarts at zero once more
        push(6); push(6);
        walk(0, 6, -1, -1, 0, "R2");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule